// File: doc/BRIEF.md
# Hypercube Next-Hop Router

This block is the forwarding stage of one node in a binary k-cube network. Nodes carry k-bit labels, and two nodes are joined by a link exactly when their labels differ in a single bit. Link `j` of a node therefore leads to the neighbour whose label differs in bit `j`. A packet arrives with a destination label. The router XORs that label with the node's own label, picks one differing bit and sends the packet out on the link for that dimension. When no bit differs, it hands the packet to the local port. Each hop clears one differing bit, so a route takes exactly as many hops as there are differing bits, and never more than k.

The order input sets the order in which bits are cleared. In most-significant-first order the highest differing bit is corrected first. In least-significant-first order the lowest differing bit is corrected first. For example, a packet going from 0100 to 1011 visits 1100, 1000, 1010, 1011 in the first order and 0101, 0111, 0011, 1011 in the second.

The router has k+1 output registers: one per link and one for local delivery. Each register drives its own valid/ready stream. The input stream is valid/ready as well. The input is ready when the register chosen by the current destination is empty, or is being emptied in the same cycle. A stalled packet is held at the input, and the sender must keep `pkt_valid` and its fields stable until the packet is taken. A register whose consumer holds ready low keeps its payload. Packets headed for other registers still pass.

Top module: `hcube_next_hop`

## Requirements
- R1: After reset, every link output and the local output show valid low, and `pkt_ready` is high.
- R2: When `order_lsb` is 0 and the labels differ, an accepted packet goes to link j, where j is the index of the highest set bit of `node_id XOR pkt_dest`.
- R3: When `order_lsb` is 1 and the labels differ, an accepted packet goes to link j, where j is the index of the lowest set bit of `node_id XOR pkt_dest`.
- R4: When `pkt_dest` equals `node_id`, an accepted packet goes to the local output, and no link output is loaded by it.
- R5: A packet is accepted on a clock edge where `pkt_valid` and `pkt_ready` are both high. In the next cycle its payload appears, unchanged, on the chosen output with valid high.
- R6: While an output holds valid high and its ready is low, that output keeps valid high and its payload does not change.
- R7: An output whose valid and ready are both high drops valid in the next cycle, unless a new packet is loaded into it on the same edge. Such a load is allowed, and the new payload is then shown.
- R8: `pkt_ready` is low only when the output chosen by the current destination holds valid high with ready low. A stall on one output does not block packets bound for another.
- R9: A route driven hop by hop from source s to destination d takes exactly popcount(s XOR d) hops. Each hop flips one differing bit, in the order set by R2 or R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | K | This node's label |
| order_lsb | input | 1 | 0: correct the highest differing bit first; 1: the lowest |
| pkt_valid | input | 1 | Input packet valid |
| pkt_ready | output | 1 | Input packet taken on this edge if valid |
| pkt_dest | input | K | Destination label of the input packet |
| pkt_data | input | PAY_W | Payload of the input packet |
| lnk_valid | output | K | Per-link output valid; bit j is the link across dimension j |
| lnk_ready | input | K | Per-link output ready |
| lnk_data | output | K*PAY_W | Per-link payloads; link j occupies bits j*PAY_W and up |
| loc_valid | output | 1 | Local delivery valid |
| loc_ready | input | 1 | Local delivery ready |
| loc_data | output | PAY_W | Local delivery payload |

## Verification
The hardest case to reach is an output that is being drained and reloaded on the same edge, while a different output stays blocked. This needs a full register, its ready rising in the same cycle as a new packet aimed at it, and a second register with ready held low. The directed stimulus first blocks one link, shows the stalled input, and sends another packet past it to a free link. It then opens the blocked link in the same cycle as a packet aimed at it. Multi-hop routes are driven by feeding each chosen neighbour back in as the node label. A long random phase then varies labels, order and readies, and a behavioural model is compared with the outputs on every clock.

// File: rtl/hnh_pkg.sv
package hnh_pkg;
  typedef enum logic {
    ORDER_MSB = 1'b0,
    ORDER_LSB = 1'b1
  } dim_order_e;
endpackage

// File: rtl/hnh_dim_pick.sv
module hnh_dim_pick
  import hnh_pkg::*;
#(
  parameter int K = 4
) (
  input  logic [K-1:0] own_lbl,
  input  logic [K-1:0] dst_lbl,
  input  dim_order_e   order,
  output logic [K-1:0] dim_oh,
  output logic         is_local
);
  logic [K-1:0] diff, rev, lo_oh, rev_oh, hi_oh;

  assign diff = own_lbl ^ dst_lbl;

  // isolate lowest set bit with two's complement
  assign lo_oh = diff & (~diff + {{(K-1){1'b0}}, 1'b1});

  // highest set bit: reverse, isolate lowest, reverse back
  for (genvar i = 0; i < K; i++) begin : g_rev
    assign rev[i]   = diff[K-1-i];
    assign hi_oh[i] = rev_oh[K-1-i];
  end
  assign rev_oh = rev & (~rev + {{(K-1){1'b0}}, 1'b1});

  assign dim_oh   = (order == ORDER_LSB) ? lo_oh : hi_oh;
  assign is_local = (diff == '0);
endmodule

// File: rtl/hnh_slot.sv
module hnh_slot #(
  parameter int PAY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PAY_W-1:0] ld_data,
  input  logic             drain_rdy,
  output logic             vld,
  output logic [PAY_W-1:0] data,
  output logic             can_load
);
  assign can_load = !vld || drain_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      data <= '0;
    end else begin
      if (load) begin
        vld  <= 1'b1;
        data <= ld_data;
      end else if (drain_rdy) begin
        vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hcube_next_hop.sv
module hcube_next_hop
  import hnh_pkg::*;
#(
  parameter int K     = 4,
  parameter int PAY_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [K-1:0]         node_id,
  input  logic                 order_lsb,
  input  logic                 pkt_valid,
  output logic                 pkt_ready,
  input  logic [K-1:0]         pkt_dest,
  input  logic [PAY_W-1:0]     pkt_data,
  output logic [K-1:0]         lnk_valid,
  input  logic [K-1:0]         lnk_ready,
  output logic [K*PAY_W-1:0]   lnk_data,
  output logic                 loc_valid,
  input  logic                 loc_ready,
  output logic [PAY_W-1:0]     loc_data
);
  localparam int NSLOT = K + 1;
  localparam int LOC   = K;

  logic [K-1:0]     dim_oh;
  logic             is_local;
  logic [NSLOT-1:0] tgt_oh, slot_free, slot_vld, slot_rdy;
  logic [PAY_W-1:0] slot_dat [NSLOT];
  logic             accept;
  dim_order_e       order;

  assign order = order_lsb ? ORDER_LSB : ORDER_MSB;

  hnh_dim_pick #(.K(K)) u_pick (
    .own_lbl  (node_id),
    .dst_lbl  (pkt_dest),
    .order    (order),
    .dim_oh   (dim_oh),
    .is_local (is_local)
  );

  assign tgt_oh    = {is_local, dim_oh};
  assign slot_rdy  = {loc_ready, lnk_ready};
  assign pkt_ready = |(tgt_oh & slot_free);
  assign accept    = pkt_valid && pkt_ready;

  for (genvar j = 0; j < NSLOT; j++) begin : g_slot
    hnh_slot #(.PAY_W(PAY_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept && tgt_oh[j]),
      .ld_data   (pkt_data),
      .drain_rdy (slot_rdy[j]),
      .vld       (slot_vld[j]),
      .data      (slot_dat[j]),
      .can_load  (slot_free[j])
    );
  end

  for (genvar j = 0; j < K; j++) begin : g_lnk
    assign lnk_data[j*PAY_W +: PAY_W] = slot_dat[j];
  end

  assign lnk_valid = slot_vld[K-1:0];
  assign loc_valid = slot_vld[LOC];
  assign loc_data  = slot_dat[LOC];
endmodule

// File: rtl/hnh_chk.sv
module hnh_chk #(
  parameter int K     = 4,
  parameter int PAY_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [K-1:0]       node_id,
  input logic               order_lsb,
  input logic               pkt_valid,
  input logic               pkt_ready,
  input logic [K-1:0]       pkt_dest,
  input logic [PAY_W-1:0]   pkt_data,
  input logic [K-1:0]       lnk_valid,
  input logic [K-1:0]       lnk_ready,
  input logic [K*PAY_W-1:0] lnk_data,
  input logic               loc_valid,
  input logic               loc_ready,
  input logic [PAY_W-1:0]   loc_data
);
  logic [K:0]       all_v, all_r;
  logic [PAY_W-1:0] all_d [K+1];
  logic [K-1:0]     diff;
  int               tgt, tgt_q;
  logic             acc, acc_q;
  logic [PAY_W-1:0] dat_q;

  assign all_v = {loc_valid, lnk_valid};
  assign all_r = {loc_ready, lnk_ready};
  assign all_d[K] = loc_data;
  for (genvar j = 0; j < K; j++) begin : g_d
    assign all_d[j] = lnk_data[j*PAY_W +: PAY_W];
  end

  assign diff = node_id ^ pkt_dest;
  always_comb begin
    tgt = K;
    if (order_lsb) begin
      for (int i = K - 1; i >= 0; i--) if (diff[i]) tgt = i;
    end else begin
      for (int i = 0; i < K; i++) if (diff[i]) tgt = i;
    end
  end
  assign acc = pkt_valid && pkt_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      tgt_q <= 0;
      dat_q <= '0;
    end else begin
      acc_q <= acc;
      tgt_q <= tgt;
      dat_q <= pkt_data;
    end
  end

  // R5 R2 R3 R4
  load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> (all_v[tgt_q] && all_d[tgt_q] == dat_q));

  // R4
  local_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && diff == '0 && (lnk_ready | ~lnk_valid) == '1) |=> (loc_valid && lnk_valid == '0));

  // R8
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |-> (all_v[tgt] && !all_r[tgt]));

  for (genvar j = 0; j <= K; j++) begin : g_slot_chk
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (all_v[j] && !all_r[j]) |=> (all_v[j] && $stable(all_d[j])));
    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (all_v[j] && all_r[j] && !(acc && tgt == j)) |=> !all_v[j]);
  end
endmodule

bind hcube_next_hop hnh_chk #(.K(K), .PAY_W(PAY_W)) u_chk (.*);

// File: tb/test_hcube_next_hop.sv
module test_hcube_next_hop;
  localparam int K = 4;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [K-1:0] node_id = '0;
  logic order_lsb = 1'b0;
  logic pkt_valid = 1'b0;
  logic pkt_ready;
  logic [K-1:0] pkt_dest = '0;
  logic [PW-1:0] pkt_data = '0;
  logic [K-1:0] lnk_valid;
  logic [K-1:0] lnk_ready = '1;
  logic [K*PW-1:0] lnk_data;
  logic loc_valid;
  logic loc_ready = 1'b1;
  logic [PW-1:0] loc_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  bit m_vld [K+1];
  logic [PW-1:0] m_dat [K+1];

  always #10 clk = ~clk;

  hcube_next_hop #(.K(K), .PAY_W(PW)) i_hcube_next_hop (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_tgt(input logic [K-1:0] s, input logic [K-1:0] d, input logic lsb);
    int t = K;
    for (int i = 0; i < K; i++) begin
      if (s[i] != d[i]) begin
        if (lsb) begin
          if (t == K) t = i;
        end else begin
          t = i;
        end
      end
    end
    return t;
  endfunction

  function automatic logic [PW-1:0] slot_dat(input int j);
    return (j == K) ? loc_data : lnk_data[j*PW +: PW];
  endfunction

  // cycle model compared on every clock
  always @(negedge clk) begin
    int t;
    bit rt, er, acc;
    logic [K:0] vv, rr;
    if (!rst_n) begin
      for (int j = 0; j <= K; j++) m_vld[j] = 0;
    end else if (!done) begin
      vv = {loc_valid, lnk_valid};
      rr = {loc_ready, lnk_ready};
      t = ref_tgt(node_id, pkt_dest, order_lsb);
      rt = rr[t];
      er = !m_vld[t] || rt;
      chk(pkt_ready === er, "R8 model pkt_ready", pkt_ready, er);
      for (int j = 0; j <= K; j++) begin
        chk(vv[j] === m_vld[j], "R7 model valid", vv[j], m_vld[j]);
        if (m_vld[j]) chk(slot_dat(j) === m_dat[j], "R5 model payload", slot_dat(j), m_dat[j]);
      end
      acc = pkt_valid && er;
      for (int j = 0; j <= K; j++) begin
        if (acc && t == j) begin
          m_vld[j] = 1;
          m_dat[j] = pkt_data;
        end else if (m_vld[j] && rr[j]) begin
          m_vld[j] = 0;
        end
      end
    end
  end

  task automatic send(input logic [K-1:0] s, input logic [K-1:0] d, input logic lsb, input logic [PW-1:0] p);
    @(posedge clk); #2;
    node_id = s; order_lsb = lsb; pkt_dest = d; pkt_data = p; pkt_valid = 1'b1;
    do @(negedge clk); while (!pkt_ready);
    @(posedge clk); #2;
    pkt_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic route(input logic [K-1:0] src, input logic [K-1:0] dst, input logic lsb,
                       output logic [K-1:0] path [K+1], output int hops);
    logic [K-1:0] cur = src;
    int t;
    hops = 0;
    for (int h = 0; h <= K + 1; h++) begin
      send(cur, dst, lsb, 16'h1000 + 16'(h));
      if (cur == dst) begin
        chk(loc_valid && lnk_valid == '0, "R4 local eject", {loc_valid, lnk_valid}, 5'h10);
        chk(loc_data == 16'h1000 + 16'(h), "R4 local payload", loc_data, 16'h1000 + h);
        break;
      end
      t = ref_tgt(cur, dst, lsb);
      chk(lnk_valid == (4'b1 << t), lsb ? "R3 lowest bit link" : "R2 highest bit link",
          lnk_valid, 4'b1 << t);
      cur = cur ^ lnk_valid;
      path[hops] = cur;
      hops++;
    end
  endtask

  initial begin
    logic [K-1:0] path [K+1];
    int hops;
    logic [K-1:0] m_hi [4] = '{4'b1100, 4'b1000, 4'b1010, 4'b1011};
    logic [K-1:0] m_lo [4] = '{4'b0101, 4'b0111, 4'b0011, 4'b1011};

    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(lnk_valid == '0 && !loc_valid, "R1 reset valids", {loc_valid, lnk_valid}, 0);
    chk(pkt_ready == 1'b1, "R1 reset ready", pkt_ready, 1);

    // R9 worked example, both orders
    route(4'b0100, 4'b1011, 1'b0, path, hops);
    chk(hops == 4, "R9 hop count msb", hops, 4);
    for (int i = 0; i < 4; i++) chk(path[i] == m_hi[i], "R9 msb path", path[i], m_hi[i]);
    route(4'b0100, 4'b1011, 1'b1, path, hops);
    chk(hops == 4, "R9 hop count lsb", hops, 4);
    for (int i = 0; i < 4; i++) chk(path[i] == m_lo[i], "R9 lsb path", path[i], m_lo[i]);

    // R9 all pairs from a few sources
    for (int s = 0; s < 16; s += 5) begin
      for (int d = 0; d < 16; d++) begin
        for (int o = 0; o < 2; o++) begin
          route(4'(s), 4'(d), o[0], path, hops);
          chk(hops == $countones(4'(s) ^ 4'(d)), "R9 hops equal popcount", hops,
              $countones(4'(s) ^ 4'(d)));
        end
      end
    end

    // R6 R8 back-pressure
    lnk_ready = '0;
    send(4'b0000, 4'b0100, 1'b0, 16'hA5A5);
    @(posedge clk); #2;
    node_id = 4'b0000; pkt_dest = 4'b0110; order_lsb = 1'b0; pkt_data = 16'hBEEF; pkt_valid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(!pkt_ready, "R8 stall on full link", pkt_ready, 0);
      chk(lnk_valid[2] && lnk_data[2*PW +: PW] == 16'hA5A5, "R6 held payload",
          lnk_data[2*PW +: PW], 16'hA5A5);
    end
    @(posedge clk); #2;
    pkt_dest = 4'b0001; pkt_data = 16'h0C0C;
    @(negedge clk);
    chk(pkt_ready, "R8 other link free", pkt_ready, 1);
    @(posedge clk); #2;
    pkt_valid = 1'b0;
    @(negedge clk);
    chk(lnk_valid == 4'b0101, "R8 passes stalled link", lnk_valid, 4'b0101);

    // R7 drain and reload on the same edge
    @(posedge clk); #2;
    lnk_ready[2] = 1'b1; pkt_dest = 4'b0110; pkt_data = 16'hBEEF; pkt_valid = 1'b1;
    @(negedge clk);
    chk(pkt_ready, "R7 ready while draining", pkt_ready, 1);
    @(posedge clk); #2;
    pkt_valid = 1'b0;
    @(negedge clk);
    chk(lnk_valid[2] && lnk_data[2*PW +: PW] == 16'hBEEF, "R7 reloaded payload",
        lnk_data[2*PW +: PW], 16'hBEEF);
    @(negedge clk);
    chk(!lnk_valid[2], "R7 released", lnk_valid[2], 0);
    lnk_ready = '1;
    repeat (2) @(negedge clk);

    // random traffic, model-checked each clock
    for (int c = 0; c < 3000; c++) begin
      @(posedge clk); #2;
      if (!(pkt_valid && !pkt_ready)) begin
        pkt_valid = ($urandom_range(0, 3) != 0);
        node_id   = 4'($urandom);
        pkt_dest  = 4'($urandom);
        order_lsb = 1'($urandom);
        pkt_data  = 16'($urandom);
      end
      lnk_ready = 4'($urandom) | 4'($urandom);
      loc_ready = ($urandom_range(0, 2) != 0);
    end
    @(posedge clk); #2;
    pkt_valid = 1'b0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    done = 1;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule